// File: doc/BRIEF.md
# Packed Multimedia Execute Unit

This unit sits beside the scalar ALU of a 32-bit MIPS-style core. It receives one instruction word per cycle, with a valid strobe and the two source operand values. It picks out the multimedia major opcode. Inside that opcode it runs a narrow decode: the function field and the shift-amount field must both match a supported operation. There are two supported operations. The first is a packed byte subtract with four independent 8-bit lanes. The second is a packed NOR, which becomes a bitwise NOT when the first operand register is register zero.

One cycle after a valid multimedia instruction, the unit reports a result, the destination register index and a write enable. A sibling sub-operation under the same opcode that is not implemented raises a reserved-instruction trap instead. Instruction words carrying any other major opcode are left alone, so that other execute units can claim them. The register file, the pipeline, the upper 96 bits of the wide architectural registers and exception vectoring are all handled outside this block.

Top module: `packed_exec_unit`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, `out_valid`, `out_wen` and `out_trap` are 0, `out_result` is 0 and `out_rd` is 0.
- R2: The major opcode is `instr[31:26]`, the function field is `instr[5:0]` and the sub-operation field is `instr[10:6]`. When `in_valid` is high and the opcode equals 0x1C, `out_valid` is 1 on the following clock edge. For exactly that cycle, it reports the outputs belonging to that instruction.
- R3: Function 0x08 with sub-operation 0x09 is the packed byte subtract. For k = 0..3, byte k of the result equals (byte k of `rs_val` − byte k of `rt_val`) mod 256. Examples: 0x10203040 − 0x01020304 = 0x0F1E2D3C, and 0x00000000 − 0x01020304 = 0xFFFEFDFC.
- R4: No borrow passes from one byte lane to the next. For example, 0x12345600 − 0x00000001 = 0x123456FF.
- R5: Function 0x29 with sub-operation 0x13 is the packed NOR, with result ~(`rs_val` | `rt_val`). Examples: 0 NOR 0 = 0xFFFFFFFF, 0 NOR 0xAAAAAAAA = 0x55555555, and 0xF0F0F0F0 NOR 0x0F0F0F0F = 0.
- R6: Any other function/sub-operation pair under opcode 0x1C gives `out_trap` = 1, `out_wen` = 0 and `out_result` = 0. This includes function 0x08 with any sub-operation other than 0x09.
- R7: A cycle with `in_valid` low, or with an opcode other than 0x1C, gives `out_valid`, `out_wen` and `out_trap` all 0 and `out_result` = 0 on the next edge.
- R8: `out_rd` reports `instr[15:11]`. For a recognised operation, `out_wen` = 1 unless that field is 0. In that case `out_wen` = 0, but `out_result` still carries the computed value. Examples: word 0x712A1248 decodes as the byte subtract with rs = 9, rt = 10, rd = 2, and word 0x70091CE9 decodes as the NOR with rs = 0, rt = 9, rd = 3.
- R9: `out_wen` and `out_trap` are never 1 together, and neither is 1 while `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word and operands are valid this cycle |
| instr | input | 32 | Instruction word |
| rs_val | input | 32 | Value of the first source register |
| rt_val | input | 32 | Value of the second source register |
| out_valid | output | 1 | A multimedia instruction completed this cycle |
| out_result | output | 32 | Computed result (zero on trap or idle) |
| out_rd | output | 5 | Destination register index |
| out_wen | output | 1 | Register write enable |
| out_trap | output | 1 | Reserved-instruction trap |

## Verification
Three operand pairs exercise the byte subtract. A pair with every lane positive separates true lane-wise subtraction from a full-word subtract only through its decode. A pair where every lane underflows shows that each lane wraps on its own. A pair where only the low lane borrows catches any borrow that leaks into byte 1. The NOR is tried with all-zero operands, an alternating-bit pattern against register zero, and two complementary nibble patterns; together these separate NOR from OR, XOR and plain NOT. Sibling encodings differ from a supported one only in the sub-operation or function field. They are placed next to idle cycles, foreign opcodes and a destination of zero, which shows that the trap, the ignore path and the write-enable suppression each act alone.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

    localparam int OPC_W   = 6;
    localparam int FN_W    = 6;
    localparam int SA_W    = 5;
    localparam int RIDX_W  = 5;

    localparam logic [OPC_W-1:0] OPC_MULTIMEDIA = 6'h1C;
    localparam logic [FN_W-1:0]  FN_GROUP0      = 6'h08;
    localparam logic [SA_W-1:0]  SA_BYTE_SUB    = 5'h09;
    localparam logic [FN_W-1:0]  FN_GROUP3      = 6'h29;
    localparam logic [SA_W-1:0]  SA_PACKED_NOR  = 5'h13;

    typedef enum logic [1:0] {
        PMU_NONE = 2'd0,
        PMU_BSUB = 2'd1,
        PMU_NOR  = 2'd2,
        PMU_RSVD = 2'd3
    } pmu_op_e;

    typedef struct packed {
        logic [OPC_W-1:0]  opcode;
        logic [RIDX_W-1:0] rs;
        logic [RIDX_W-1:0] rt;
        logic [RIDX_W-1:0] rd;
        logic [SA_W-1:0]   sa;
        logic [FN_W-1:0]   funct;
    } pmu_fields_t;

    function automatic pmu_fields_t pmu_split(input logic [31:0] w);
        pmu_fields_t f;
        f.opcode = w[31:26];
        f.rs     = w[25:21];
        f.rt     = w[20:16];
        f.rd     = w[15:11];
        f.sa     = w[10:6];
        f.funct  = w[5:0];
        return f;
    endfunction

endpackage

// File: rtl/pmu_decode.sv
module pmu_decode
    import pmu_pkg::*;
(
    input  logic                valid,
    input  logic [31:0]         instr,
    output pmu_op_e             op,
    output logic [RIDX_W-1:0]   rd
);
    pmu_fields_t f;

    always_comb begin
        f  = pmu_split(instr);
        rd = f.rd;
        op = PMU_NONE;
        if (valid && f.opcode == OPC_MULTIMEDIA) begin
            if (f.funct == FN_GROUP0 && f.sa == SA_BYTE_SUB)
                op = PMU_BSUB;
            else if (f.funct == FN_GROUP3 && f.sa == SA_PACKED_NOR)
                op = PMU_NOR;
            else
                op = PMU_RSVD;
        end
    end
endmodule

// File: rtl/pmu_lane_sub.sv
module pmu_lane_sub #(
    parameter int DATA_W = 32,
    parameter int LANE_W = 8
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] diff
);
    localparam int LANES = DATA_W / LANE_W;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign diff[k*LANE_W +: LANE_W] = a[k*LANE_W +: LANE_W] - b[k*LANE_W +: LANE_W];
    end
endmodule

// File: rtl/pmu_outreg.sv
module pmu_outreg #(
    parameter int DATA_W = 32
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      d_valid,
    input  logic [DATA_W-1:0]         d_result,
    input  logic [pmu_pkg::RIDX_W-1:0] d_rd,
    input  logic                      d_wen,
    input  logic                      d_trap,
    output logic                      q_valid,
    output logic [DATA_W-1:0]         q_result,
    output logic [pmu_pkg::RIDX_W-1:0] q_rd,
    output logic                      q_wen,
    output logic                      q_trap
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q_valid  <= 1'b0;
            q_result <= '0;
            q_rd     <= '0;
            q_wen    <= 1'b0;
            q_trap   <= 1'b0;
        end else begin
            q_valid  <= d_valid;
            q_result <= d_result;
            q_rd     <= d_rd;
            q_wen    <= d_wen;
            q_trap   <= d_trap;
        end
    end
endmodule

// File: rtl/packed_exec_unit.sv
module packed_exec_unit
    import pmu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [31:0]       instr,
    input  logic [DATA_W-1:0] rs_val,
    input  logic [DATA_W-1:0] rt_val,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_result,
    output logic [4:0]        out_rd,
    output logic              out_wen,
    output logic              out_trap
);
    pmu_op_e           op;
    logic [RIDX_W-1:0] dec_rd;
    logic [DATA_W-1:0] sub_res;
    logic [DATA_W-1:0] nor_res;
    logic              n_valid;
    logic [DATA_W-1:0] n_result;
    logic [RIDX_W-1:0] n_rd;
    logic              n_wen;
    logic              n_trap;

    pmu_decode u_dec (
        .valid (in_valid),
        .instr (instr),
        .op    (op),
        .rd    (dec_rd)
    );

    pmu_lane_sub #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_sub (
        .a    (rs_val),
        .b    (rt_val),
        .diff (sub_res)
    );

    assign nor_res = ~(rs_val | rt_val);

    always_comb begin
        n_valid  = (op != PMU_NONE);
        n_rd     = n_valid ? dec_rd : '0;
        n_trap   = (op == PMU_RSVD);
        n_wen    = 1'b0;
        n_result = '0;
        case (op)
            PMU_BSUB: begin
                n_result = sub_res;
                n_wen    = (dec_rd != '0);
            end
            PMU_NOR: begin
                n_result = nor_res;
                n_wen    = (dec_rd != '0);
            end
            default: ;
        endcase
    end

    pmu_outreg #(.DATA_W(DATA_W)) u_reg (
        .clk      (clk),
        .rst      (rst),
        .d_valid  (n_valid),
        .d_result (n_result),
        .d_rd     (n_rd),
        .d_wen    (n_wen),
        .d_trap   (n_trap),
        .q_valid  (out_valid),
        .q_result (out_result),
        .q_rd     (out_rd),
        .q_wen    (out_wen),
        .q_trap   (out_trap)
    );
endmodule

// File: rtl/pmu_checker.sv
module pmu_checker #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [31:0]       instr,
    input logic [DATA_W-1:0] rs_val,
    input logic [DATA_W-1:0] rt_val,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_result,
    input logic [4:0]        out_rd,
    input logic              out_wen,
    input logic              out_trap
);
    AST_WEN_TRAP_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(out_wen && out_trap));  // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (!out_wen && !out_trap && out_result == '0));  // R7

    AST_MM_RESPONDS: assert property (@(posedge clk) disable iff (rst)
        (in_valid && instr[31:26] == 6'h1C) |=> out_valid);  // R2

    AST_FOREIGN_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (!in_valid || instr[31:26] != 6'h1C) |=> !out_valid);  // R7

    AST_RD_ZERO_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_rd == 5'd0) |-> !out_wen);  // R8

    AST_TRAP_ZERO_RESULT: assert property (@(posedge clk) disable iff (rst)
        out_trap |-> out_result == '0);  // R6

    AST_NOR_RESULT: assert property (@(posedge clk) disable iff (rst)
        (in_valid && instr[31:26] == 6'h1C && instr[5:0] == 6'h29 && instr[10:6] == 5'h13)
        |=> out_result == ~($past(rs_val) | $past(rt_val)));  // R5
endmodule

bind packed_exec_unit pmu_checker #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .instr      (instr),
    .rs_val     (rs_val),
    .rt_val     (rt_val),
    .out_valid  (out_valid),
    .out_result (out_result),
    .out_rd     (out_rd),
    .out_wen    (out_wen),
    .out_trap   (out_trap)
);

// File: tb/packed_exec_unit_test.sv
`timescale 1ns/1ps
module packed_exec_unit_test;

    typedef struct {
        logic        valid;
        logic [31:0] result;
        logic [4:0]  rd;
        logic        wen;
        logic        trap;
        string       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] rs_val = '0;
    logic [31:0] rt_val = '0;
    logic        out_valid;
    logic [31:0] out_result;
    logic [4:0]  out_rd;
    logic        out_wen;
    logic        out_trap;

    int   n_checks = 0;
    int   n_fail   = 0;
    bit   mon_on   = 1'b0;
    bit   done     = 1'b0;
    exp_t sb[$];

    always #2 clk = ~clk;  // 250 MHz

    packed_exec_unit uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
        .rs_val(rs_val), .rt_val(rt_val), .out_valid(out_valid),
        .out_result(out_result), .out_rd(out_rd), .out_wen(out_wen),
        .out_trap(out_trap)
    );

    function automatic logic [31:0] enc(input logic [5:0] op, input logic [4:0] rs,
                                        input logic [4:0] rt, input logic [4:0] rd,
                                        input logic [4:0] sa, input logic [5:0] fn);
        return {op, rs, rt, rd, sa, fn};
    endfunction

    // Reference built from the requirement text
    function automatic exp_t model(input logic v, input logic [31:0] w,
                                   input logic [31:0] a, input logic [31:0] b, input string req);
        exp_t e;
        e.req = req; e.valid = 0; e.result = 0; e.rd = 0; e.wen = 0; e.trap = 0;
        if (v && w[31:26] == 6'h1C) begin
            e.valid = 1;
            e.rd = w[15:11];
            if (w[5:0] == 6'h08 && w[10:6] == 5'h09) begin
                for (int k = 0; k < 4; k++) begin
                    e.result[k*8 +: 8] = 8'(a[k*8 +: 8] - b[k*8 +: 8]);
                end
                e.wen = (w[15:11] != 0);
            end else if (w[5:0] == 6'h29 && w[10:6] == 5'h13) begin
                e.result = ~(a | b);
                e.wen = (w[15:11] != 0);
            end else begin
                e.trap = 1;
            end
        end
        return e;
    endfunction

    task automatic check(input string req, input string what, input logic [31:0] act,
                         input logic [31:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s %s: actual=0x%08h expected=0x%08h", req, what, act, expv);
        end
    endtask

    task automatic drive(input logic v, input logic [31:0] w, input logic [31:0] a,
                         input logic [31:0] b, input string req);
        @(negedge clk);
        in_valid = v; instr = w; rs_val = a; rt_val = b;
        sb.push_back(model(v, w, a, b, req));
    endtask

    task automatic drive_expect(input logic [31:0] w, input logic [31:0] a,
                                input logic [31:0] b, input logic [31:0] want, input string req);
        exp_t e;
        e = model(1'b1, w, a, b, req);
        check(req, "reference value", e.result, want);
        drive(1'b1, w, a, b, req);
    endtask

    // Monitor: compare each cycle's outputs with the oldest expectation
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (mon_on && sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check(e.req, "out_valid",  32'(out_valid),  32'(e.valid));
                check(e.req, "out_result", out_result,      e.result);
                check(e.req, "out_rd",     32'(out_rd),     32'(e.rd));
                check(e.req, "out_wen",    32'(out_wen),    32'(e.wen));
                check(e.req, "out_trap",   32'(out_trap),   32'(e.trap));
            end
        end
    end

    initial begin
        #200000;
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: outputs during reset, with a multimedia word at the input
        in_valid = 1'b1; instr = 32'h712A1248; rs_val = 32'h10203040; rt_val = 32'h01020304;
        repeat (3) @(posedge clk);
        #1;
        check("R1", "reset valid", 32'(out_valid), 0);
        check("R1", "reset result", out_result, 0);
        check("R1", "reset rd/wen/trap", {out_rd, out_wen, out_trap}, 0);
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b0;
        @(posedge clk);
        #1;
        check("R1", "first cycle after reset", {out_valid, out_wen, out_trap}, 0);
        mon_on = 1'b1;

        // R3 / R8: given encoding decodes as byte subtract rs=9 rt=10 rd=2
        check("R8", "subtract word", 32'h712A1248, enc(6'h1C, 5'd9, 5'd10, 5'd2, 5'h09, 6'h08));
        drive_expect(32'h712A1248, 32'h10203040, 32'h01020304, 32'h0F1E2D3C, "R3");
        drive_expect(enc(6'h1C, 5'd11, 5'd12, 5'd13, 5'h09, 6'h08),
                     32'h00000000, 32'h01020304, 32'hFFFEFDFC, "R3");
        // R4: borrow stays in lane 0
        drive_expect(enc(6'h1C, 5'd14, 5'd15, 5'd24, 5'h09, 6'h08),
                     32'h12345600, 32'h00000001, 32'h123456FF, "R4");
        drive(1'b0, 32'h712A1248, 32'h1, 32'h2, "R7");

        // R5 / R8: NOR word decodes with rs=0 rt=9 rd=3
        check("R8", "nor word", 32'h70091CE9, enc(6'h1C, 5'd0, 5'd9, 5'd3, 5'h13, 6'h29));
        drive_expect(32'h70091CE9, 32'h0, 32'hAAAAAAAA, 32'h55555555, "R5");
        drive_expect(32'h70091CE9, 32'h0, 32'h0, 32'hFFFFFFFF, "R5");
        drive_expect(enc(6'h1C, 5'd4, 5'd5, 5'd6, 5'h13, 6'h29),
                     32'hF0F0F0F0, 32'h0F0F0F0F, 32'h0, "R5");

        // R6: siblings that must trap
        drive(1'b1, enc(6'h1C, 5'd9, 5'd10, 5'd2, 5'h08, 6'h08), 32'h11, 32'h22, "R6");
        drive(1'b1, enc(6'h1C, 5'd9, 5'd10, 5'd2, 5'h12, 6'h29), 32'h11, 32'h22, "R6");
        drive(1'b1, enc(6'h1C, 5'd9, 5'd10, 5'd2, 5'h09, 6'h00), 32'h11, 32'h22, "R6");
        drive(1'b1, enc(6'h1C, 5'd9, 5'd10, 5'd7, 5'h13, 6'h08), 32'h11, 32'h22, "R6");

        // R7: foreign opcodes and idle cycles (same funct/sa as supported ops)
        drive(1'b1, enc(6'h00, 5'd9, 5'd10, 5'd2, 5'h09, 6'h08), 32'h5, 32'h3, "R7");
        drive(1'b1, enc(6'h1D, 5'd9, 5'd10, 5'd2, 5'h13, 6'h29), 32'h5, 32'h3, "R7");
        drive(1'b0, 32'h70091CE9, 32'h0, 32'h0, "R7");

        // R8: destination 0 keeps result, drops write
        drive(1'b1, enc(6'h1C, 5'd9, 5'd10, 5'd0, 5'h09, 6'h08), 32'h0A0B0C0D, 32'h01010101, "R8");
        drive(1'b1, enc(6'h1C, 5'd0, 5'd1, 5'd0, 5'h13, 6'h29), 32'h0, 32'h0000FFFF, "R8");

        // R2 / R9: back-to-back mix
        for (int i = 0; i < 16; i++) begin
            logic [31:0] a, b, w;
            a = 32'h9E3779B9 * (i + 1);
            b = 32'h7F4A7C15 ^ (a >> 3);
            case (i % 4)
                0: w = enc(6'h1C, 5'(i), 5'(i + 1), 5'(i), 5'h09, 6'h08);
                1: w = enc(6'h1C, 5'(i), 5'(i + 1), 5'(i), 5'h13, 6'h29);
                2: w = enc(6'h1C, 5'(i), 5'(i + 1), 5'(i), 5'(i), 6'h29);
                default: w = enc(6'(i), 5'(i), 5'(i + 1), 5'(i), 5'h09, 6'h08);
            endcase
            drive(1'b1, w, a, b, "R2");
        end
        drive(1'b0, 32'h0, 32'h0, 32'h0, "R7");
        @(negedge clk);
        in_valid = 1'b0;
        repeat (4) @(posedge clk);
        #2;
        check("R2", "scoreboard drained", sb.size(), 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule